// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Interval Timer

This block sequences processor interrupt entry and return, and it contains a down-counting interval timer that raises one of the interrupt sources. Four sources feed it: a system-call request, the timer, a disk-completion pulse and a program-error request that carries a two-bit parameter. Each request is first captured in a pending register. On the following clock edge the highest-priority eligible cause is taken. Taking a cause copies the status word into a saved-status register and the current instruction address into a saved-address register. It then clears the status word, writes the error parameter when the cause is a program error, and sends the core to the vector area base plus four times the cause index.

Status bit 0 masks the timer and disk sources. A masked request stays pending and is delivered once that bit is clear again. The system-call and program-error sources are never masked. A return strobe puts the saved status word back and sends the core to the saved address in a single cycle. The status word also has a plain write port that the core uses for control-register loads.

Top module: `intr_seq`

## Requirements
- R1: On entry, the saved-status output takes the status word held before entry, and the status word becomes zero.
- R2: On entry, the saved-address output takes the value of `cur_ia` at the entry edge.
- R3: A program-error entry writes its code zero-extended into `ip`: 0 for an undefined instruction, 1 for an illegal user-mode instruction, 2 for a bound violation. Entries for other causes leave `ip` unchanged.
- R4: A request sampled at one clock edge produces entry at the next edge. Entry pulses `vec_go` high for one cycle, drives `cause` with the index (syscall 0, timer 1, disk 2, program error 3), and drives `next_ia` = `vec_base` + 4*index.
- R5: When `us_tick` is high and no write occurs, a nonzero timer decrements by one. A timer at zero stays at zero.
- R6: The timer raises its request only on a tick that moves it from 1 to 0. A timer write takes priority over the tick in the same cycle and raises no request.
- R7: While status bit 0 is 1, timer and disk requests stay pending without entry. They are taken once bit 0 is 0.
- R8: System-call and program-error requests are taken whatever the value of status bit 0.
- R9: When several eligible causes are pending, they are taken one per cycle in the order program error, system call, timer, disk.
- R10: A return strobe sets, at the next edge, the status word to the saved status, `next_ia` to the saved address, and pulses `ret_go`. In that cycle the return wins over entry, and the entry follows one cycle later.
- R11: `psw_wr` loads `psw_wdata` into the status word when neither entry nor return happens in that cycle.
- R12: After reset the status word, saved registers, parameter, timer and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | Microsecond enable for the timer |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | TW | Timer load value |
| sys_req | input | 1 | System-call request |
| err_req | input | 1 | Program-error request |
| err_code | input | 2 | Program-error parameter |
| disk_done | input | 1 | Disk completion pulse |
| rfi | input | 1 | Return-from-interrupt strobe |
| cur_ia | input | AW | Current instruction address |
| vec_base | input | AW | Interrupt vector area base |
| psw_wr | input | 1 | Status word write strobe |
| psw_wdata | input | PW | Status word write value |
| psw | output | PW | Status word |
| ipsw | output | PW | Saved status word |
| iia | output | AW | Saved instruction address |
| ip | output | AW | Interrupt parameter |
| tmr_val | output | TW | Timer count |
| vec_go | output | 1 | Entry pulse |
| ret_go | output | 1 | Return pulse |
| cause | output | 2 | Cause index of the last entry |
| next_ia | output | AW | Redirect address |

## Verification
A corrupted pending bit shows up as an entry that never comes, or as a spurious `vec_go` with the wrong `cause`. It appears two edges after the request, or as soon as the mask bit clears. A wrong timer count is seen on `tmr_val` at the next tick, and a misplaced 1-to-0 detection shows as an entry one tick early or late. Faults in the save or restore paths appear on `ipsw`, `iia` and `psw` in the very cycle that `vec_go` or `ret_go` is high.

// File: rtl/intr_seq.sv
module intr_seq #(
  parameter int AW = 32,
  parameter int PW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          tmr_wr,
  input  logic [TW-1:0] tmr_wdata,
  input  logic          sys_req,
  input  logic          err_req,
  input  logic [1:0]    err_code,
  input  logic          disk_done,
  input  logic          rfi,
  input  logic [AW-1:0] cur_ia,
  input  logic [AW-1:0] vec_base,
  input  logic          psw_wr,
  input  logic [PW-1:0] psw_wdata,
  output logic [PW-1:0] psw,
  output logic [PW-1:0] ipsw,
  output logic [AW-1:0] iia,
  output logic [AW-1:0] ip,
  output logic [TW-1:0] tmr_val,
  output logic          vec_go,
  output logic          ret_go,
  output logic [1:0]    cause,
  output logic [AW-1:0] next_ia
);

  localparam logic [1:0] C_SYS = 2'd0, C_TMR = 2'd1, C_DSK = 2'd2, C_ERR = 2'd3;

  logic [3:0] pend, elig, take_vec, new_ev;
  logic [1:0] ecode_q, sel;
  logic       tmr_fire, take;

  assign tmr_fire = us_tick && !tmr_wr && (tmr_val == TW'(1));
  assign new_ev   = {err_req, disk_done, tmr_fire, sys_req};
  assign elig     = pend & {1'b1, ~psw[0], ~psw[0], 1'b1};
  assign take     = (|elig) && !rfi;

  always_comb begin
    if (elig[C_ERR])      sel = C_ERR;
    else if (elig[C_SYS]) sel = C_SYS;
    else if (elig[C_TMR]) sel = C_TMR;
    else                  sel = C_DSK;
  end

  assign take_vec = take ? (4'b0001 << sel) : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) tmr_val <= '0;
    else if (tmr_wr) tmr_val <= tmr_wdata;
    else if (us_tick && tmr_val != '0) tmr_val <= tmr_val - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      ecode_q <= '0;
    end else begin
      pend <= (pend & ~take_vec) | new_ev;
      if (err_req) ecode_q <= err_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psw     <= '0;
      ipsw    <= '0;
      iia     <= '0;
      ip      <= '0;
      vec_go  <= 1'b0;
      ret_go  <= 1'b0;
      cause   <= '0;
      next_ia <= '0;
    end else begin
      vec_go <= take;
      ret_go <= rfi;
      if (rfi) begin
        psw     <= ipsw;
        next_ia <= iia;
      end else if (take) begin
        ipsw    <= psw;
        psw     <= '0;
        iia     <= cur_ia;
        cause   <= sel;
        next_ia <= vec_base + AW'({sel, 2'b00});
        if (sel == C_ERR) ip <= AW'(ecode_q);
      end else if (psw_wr) begin
        psw <= psw_wdata;
      end
    end
  end

  p_save_psw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (psw == '0) && (ipsw == $past(psw)));

  p_save_ia_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> iia == $past(cur_ia));

  p_vec_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_go |-> next_ia == vec_base + AW'({cause, 2'b00}));

  p_tmr_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (us_tick && !tmr_wr && tmr_val != '0) |=> tmr_val == $past(tmr_val) - TW'(1));

  p_tmr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!us_tick && !tmr_wr) |=> $stable(tmr_val));

  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_go && (cause == C_TMR || cause == C_DSK)) |-> !$past(psw[0]));

  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rfi |=> ret_go && !vec_go && psw == $past(ipsw) && next_ia == $past(iia));

  p_one_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_go && ret_go));

endmodule

// File: tb/tb_intr_seq.sv
module tb_intr_seq;
  localparam int AW = 32, PW = 8, TW = 8;
  localparam logic [AW-1:0] VB = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic us_tick = 0, tmr_wr = 0, sys_req = 0, err_req = 0, disk_done = 0, rfi = 0, psw_wr = 0;
  logic [TW-1:0] tmr_wdata = '0;
  logic [1:0] err_code = '0;
  logic [AW-1:0] cur_ia = 32'h0000_4440;
  logic [AW-1:0] vec_base = VB;
  logic [PW-1:0] psw_wdata = '0;
  logic [PW-1:0] psw, ipsw;
  logic [AW-1:0] iia, ip, next_ia;
  logic [TW-1:0] tmr_val;
  logic vec_go, ret_go;
  logic [1:0] cause;

  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intr_seq #(.AW(AW), .PW(PW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .sys_req(sys_req), .err_req(err_req), .err_code(err_code), .disk_done(disk_done),
    .rfi(rfi), .cur_ia(cur_ia), .vec_base(vec_base), .psw_wr(psw_wr), .psw_wdata(psw_wdata),
    .psw(psw), .ipsw(ipsw), .iia(iia), .ip(ip), .tmr_val(tmr_val), .vec_go(vec_go),
    .ret_go(ret_go), .cause(cause), .next_ia(next_ia));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input longint act, input longint exp);
    chk(act == exp, tag, act, exp);
  endtask

  function automatic int prio(input logic [3:0] e);
    if (e[3]) return 3;
    if (e[0]) return 0;
    if (e[1]) return 1;
    return 2;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_psw(input logic [PW-1:0] v);
    psw_wr = 1; psw_wdata = v;
    @(negedge clk);
    psw_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle(3);
    eq("R12 psw", psw, 0); eq("R12 ipsw", ipsw, 0); eq("R12 iia", iia, 0);
    eq("R12 ip", ip, 0); eq("R12 tmr", tmr_val, 0); eq("R12 vec_go", vec_go, 0);
    eq("R12 ret_go", ret_go, 0);
    rst_n = 1;
    idle(1);

    // R11 write port
    wr_psw(8'h3C);
    eq("R11 psw write", psw, 8'h3C);

    // R5/R6 timer countdown
    tmr_wr = 1; tmr_wdata = 8'd5; @(negedge clk); tmr_wr = 0;
    eq("R5 load", tmr_val, 5);
    for (int k = 4; k >= 1; k--) begin
      us_tick = 1; @(negedge clk); us_tick = 0;
      eq("R5 dec", tmr_val, k);
      eq("R6 no early fire", vec_go, 0);
      idle(1);
      eq("R6 no early fire2", vec_go, 0);
    end
    wr_psw(8'h00);
    us_tick = 1; @(negedge clk); us_tick = 0;
    eq("R5 reach zero", tmr_val, 0);
    @(negedge clk);
    eq("R6 fire entry", vec_go, 1);
    eq("R4 cause tmr", cause, 1);
    eq("R4 vec tmr", next_ia, VB + 4);
    us_tick = 1; idle(3); us_tick = 0;
    eq("R5 hold zero", tmr_val, 0);
    eq("R6 no refire", vec_go, 0);

    // R6 write beats tick
    tmr_wr = 1; tmr_wdata = 8'd1; @(negedge clk);
    tmr_wdata = 8'd3; us_tick = 1; @(negedge clk); tmr_wr = 0; us_tick = 0;
    eq("R6 write priority", tmr_val, 3);
    @(negedge clk);
    eq("R6 no fire on write", vec_go, 0);
    tmr_wr = 1; tmr_wdata = 0; @(negedge clk); tmr_wr = 0;
    idle(4);

    // R3 error parameter sweep
    for (int c = 0; c < 3; c++) begin
      cur_ia = 32'h0000_2000 + c * 16;
      err_req = 1; err_code = 2'(c); @(negedge clk); err_req = 0;
      @(negedge clk);
      eq("R3 err entry", vec_go, 1);
      eq("R3 ip code", ip, c);
      eq("R2 iia err", iia, cur_ia);
      eq("R4 vec err", next_ia, VB + 12);
    end
    sys_req = 1; @(negedge clk); sys_req = 0; @(negedge clk);
    eq("R4 sys entry", vec_go, 1);
    eq("R4 cause sys", cause, 0);
    eq("R3 ip untouched", ip, 2);
    idle(3);

    // R1/R7/R8/R9 sweep over source combinations and mask
    for (int m = 0; m < 2; m++) begin
      for (int s = 1; s < 16; s++) begin
        logic [3:0] sv, el;
        logic [PW-1:0] pv;
        sv = 4'(s);
        pv = 8'h50 | 8'(m);
        cur_ia = 32'h0000_8000 + s * 4 + m * 256;
        el = sv & ((m == 1) ? 4'b1001 : 4'b1111);
        psw_wr = 1; psw_wdata = pv;
        if (sv[1]) begin tmr_wr = 1; tmr_wdata = 8'd1; end
        @(negedge clk);
        psw_wr = 0; tmr_wr = 0;
        sys_req = sv[0]; us_tick = sv[1]; disk_done = sv[2]; err_req = sv[3]; err_code = 2'd2;
        @(negedge clk);
        sys_req = 0; us_tick = 0; disk_done = 0; err_req = 0;
        @(negedge clk);
        if (el != 0) begin
          eq(m ? "R8 unmasked entry" : "R9 entry", vec_go, 1);
          eq("R9 cause", cause, prio(el));
          eq("R4 vec", next_ia, VB + 4 * prio(el));
          eq("R1 ipsw", ipsw, pv);
          eq("R1 psw cleared", psw, 0);
          eq("R2 iia", iia, cur_ia);
        end else begin
          eq("R7 masked no entry", vec_go, 0);
          eq("R7 psw kept", psw, pv);
          idle(2);
          eq("R7 still held", vec_go, 0);
          wr_psw(8'h00);
          @(negedge clk);
          eq("R7 delivered", vec_go, 1);
          eq("R7 cause", cause, prio(sv));
        end
        idle(8);
      end
    end

    // R10 return and its precedence
    cur_ia = 32'h0000_9990;
    wr_psw(8'h81);
    sys_req = 1; @(negedge clk); sys_req = 0; @(negedge clk);
    eq("R10 setup entry", vec_go, 1);
    eq("R1 ipsw setup", ipsw, 8'h81);
    cur_ia = 32'h0000_1234;
    rfi = 1; @(negedge clk); rfi = 0;
    eq("R10 ret pulse", ret_go, 1);
    eq("R10 psw restored", psw, 8'h81);
    eq("R10 next_ia", next_ia, 32'h0000_9990);
    eq("R10 no entry", vec_go, 0);
    sys_req = 1; @(negedge clk); sys_req = 0;
    rfi = 1; @(negedge clk); rfi = 0;
    eq("R10 ret wins", ret_go, 1);
    eq("R10 entry deferred", vec_go, 0);
    @(negedge clk);
    eq("R10 entry after ret", vec_go, 1);
    eq("R10 ipsw after ret", ipsw, 8'h81);
    eq("R2 iia after ret", iia, 32'h0000_1234);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule